// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block drives a three-wire serial audio link as the clock master. It divides a fast reference clock into a bit clock, produces a word-select or frame-sync line, and shifts out parallel 24-bit channel words MSB first. A two-bit format code selects one of four formats. Left-justified, I2S and right-justified formats carry a stereo pair. The TDM format carries eight channels, which are four stereo pairs, in one frame.

A second two-bit code sets the output word length to 24, 20, 18 or 16 bits. For lengths below 24 bits, a pseudo-random dither bit from a free-running LFSR is added, with saturation, one position below the lowest kept bit before the word is truncated. A packing input selects a compact 32-bit-clock stereo frame with 16-bit words. The block samples all channel inputs once per frame and pulses a strobe at that moment, so upstream logic can present the next frame's words.

Top module: `serial_audio_tx`

## Requirements
- R1: While reset is asserted, bclk_o is 1 and ws_o, sdata_o and take_o are 0. The first reference edge after reset lowers bclk_o and begins bit position 0 of a frame.
- R2: bclk_o has a period of 2*HALF reference cycles. sdata_o and ws_o change only in the cycle where bclk_o falls, so a receiver can sample on the rising edge.
- R3: With format code 00 (left-justified), a frame is 64 bit clocks. ws_o is 1 for the 32 clocks carrying channel 0 and 0 for the 32 carrying channel 1. The MSB is on the first clock of each half.
- R4: With format code 01 (I2S), ws_o is 0 for the channel-0 half and 1 for the channel-1 half. Each MSB follows one bit clock after the ws_o transition. The capture strobe is issued at frame position 1.
- R5: With format code 11 (right-justified), each half is 32 clocks with ws_o as in R3. The word's LSB is on the last bit clock before the ws_o transition.
- R6: With format code 10 (TDM), a frame is 256 bit clocks made of eight 32-clock slots, with channel c in slot c. ws_o is a pulse one bit clock wide at frame position 0, and each slot's MSB is on its first clock.
- R7: Width code 00/01/10/11 selects 24/20/18/16 transmitted bits per word, MSB first.
- R8: For lengths below 24, each transmitted word equals either the plain truncation of the sample or the truncation of the sample plus one unit just below the kept LSB. Both outcomes occur over many frames. At 24 bits the word is sent unchanged.
- R9: A positive sample never wraps through dither: 0x7FFFFF is sent as the largest positive word of the selected length.
- R10: Every bit clock outside a word's data positions carries sdata_o = 0.
- R11: When pack_i is 1 and the format is not TDM, the frame is 32 bit clocks with 16 per channel, and words are 16 bits regardless of the width code. pack_i has no effect in TDM.
- R12: take_o is a one-cycle pulse issued exactly once per frame. The channel words sent in that frame are the smp_i values present at that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Format: 00 left-justified, 01 I2S, 10 TDM, 11 right-justified |
| wlen_i | input | 2 | Word length: 00 24, 01 20, 10 18, 11 16 bits |
| pack_i | input | 1 | Compact 16-bit, 32-clock stereo frame (ignored in TDM) |
| smp_i | input | NCH*24 | Channel words, channel c at bits [24c+23:24c], two's complement |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, or frame sync pulse in TDM |
| sdata_o | output | 1 | Serial data, MSB first |
| take_o | output | 1 | One-cycle strobe when smp_i is captured |

## Verification
Two events share a single bit-clock step: capturing the new frame's words and emitting a bit. In left-justified, right-justified and TDM formats, the first bit after capture must come from the freshly captured words. In packed I2S, position 0 still carries the previous frame's right-channel LSB, and the capture follows at position 1. The bench changes smp_i immediately after every take_o. It then rebuilds each frame from the rising bit-clock edges and compares it with the words recorded at that strobe, so a bit taken from the wrong frame shows up as a word mismatch. The same step also combines saturation with dither: a directed 0x7FFFFF word at 16 bits must arrive unwrapped.

// File: rtl/txa_pkg.sv
package txa_pkg;

    localparam int SMP_W = 24;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_TDM = 2'b10,
        FMT_RJ  = 2'b11
    } fmt_e;

    // Number of transmitted bits for a width code; packing forces 16.
    function automatic logic [4:0] word_bits(input logic [1:0] code, input logic pk);
        logic [4:0] r;
        if (pk) begin
            r = 5'd16;
        end else begin
            case (code)
                2'b00:   r = 5'd24;
                2'b01:   r = 5'd20;
                2'b10:   r = 5'd18;
                default: r = 5'd16;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/txa_clkgen.sv
module txa_clkgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_o,
    output logic step_o
);
    localparam int PER = 2 * HALF;
    localparam int CW  = (PER > 1) ? $clog2(PER) : 1;
    localparam logic [CW-1:0] LAST = CW'(PER - 1);
    localparam logic [CW-1:0] HI   = CW'(HALF);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } cg_t;

    cg_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.cnt  = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        s_d.bclk = (s_d.cnt >= HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= LAST;
            s_q.bclk <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bclk_o = s_q.bclk;
    // The next edge is a falling bit-clock edge.
    assign step_o = (s_q.cnt == LAST);

endmodule

// File: rtl/txa_dither.sv
module txa_dither
    import txa_pkg::*;
#(
    parameter int          NCH  = 8,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*SMP_W-1:0] smp_i,
    input  logic [4:0]           bits_i,
    output logic [NCH*SMP_W-1:0] word_o
);
    typedef struct packed {
        logic [15:0] lfsr;
    } dt_t;

    dt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.lfsr = {1'b0, s_q.lfsr[15:1]};
        if (s_q.lfsr[0]) s_d.lfsr = s_d.lfsr ^ 16'hB400;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.lfsr <= SEED;
        else        s_q <= s_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SMP_W-1:0] s, inc, sum, sat, mask, w;
        logic [4:0]       sh;
        always_comb begin
            s   = smp_i[c*SMP_W +: SMP_W];
            sh  = 5'd23 - bits_i;
            inc = '0;
            if (bits_i < 5'd24 && s_q.lfsr[c % 16]) inc = 24'd1 << sh;
            sum  = s + inc;
            sat  = (!s[SMP_W-1] && sum[SMP_W-1]) ? 24'h7FFFFF : sum;
            mask = ~((24'd1 << (5'd24 - bits_i)) - 24'd1);
            w    = sat & mask;
        end
        assign word_o[c*SMP_W +: SMP_W] = w;

        // R9
        sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !s[SMP_W-1] |-> !w[SMP_W-1]);
    end

endmodule

// File: rtl/txa_framer.sv
module txa_framer
    import txa_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int SLOT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic                 bclk_i,
    input  logic [1:0]           fmt_i,
    input  logic                 packed_i,
    input  logic [4:0]           bits_i,
    input  logic [NCH*SMP_W-1:0] words_i,
    output logic                 ws_o,
    output logic                 sdata_o,
    output logic                 take_o
);
    localparam int FRAME_MAX = NCH * SLOT;
    localparam int PW        = $clog2(FRAME_MAX);
    localparam int SLOT_LG   = $clog2(SLOT);

    typedef struct packed {
        logic [PW-1:0]          pos;
        logic                   ws;
        logic                   sdata;
        logic                   take;
        logic [NCH*SMP_W-1:0]   shadow;
    } fr_t;

    fr_t s_d, s_q;

    int                   flen, slen, dly, pn, q, slot, k, start, idx, nb;
    logic                 on, cap, half, tdm, i2s, rj;
    logic [SMP_W-1:0]     word, tmp;
    logic [NCH*SMP_W-1:0] src;

    always_comb begin
        tdm  = (fmt_i == FMT_TDM);
        i2s  = (fmt_i == FMT_I2S);
        rj   = (fmt_i == FMT_RJ);
        nb   = int'(bits_i);
        slen = packed_i ? SLOT / 2 : SLOT;
        flen = tdm ? FRAME_MAX : 2 * slen;
        dly  = i2s ? 1 : 0;
        pn   = (int'(s_q.pos) >= flen - 1) ? 0 : int'(s_q.pos) + 1;
        cap  = (pn == dly);
        half = (pn >= slen);
        // Position within the data stream, shifted by the format delay.
        q    = (pn >= dly) ? pn - dly : flen - 1;
        slot = q >> (packed_i ? SLOT_LG - 1 : SLOT_LG);
        k    = q & (slen - 1);
        if (rj) begin
            start = slen - nb;
            on    = (k >= start);
            idx   = k - start;
        end else begin
            start = 0;
            on    = (k < nb);
            idx   = k;
        end
        src  = cap ? words_i : s_q.shadow;
        word = SMP_W'(src >> (slot * SMP_W));
        tmp  = word << idx;

        s_d      = s_q;
        s_d.take = 1'b0;
        if (step_i) begin
            s_d.pos   = PW'(pn);
            s_d.ws    = tdm ? (pn == 0) : (i2s ? half : !half);
            s_d.sdata = on ? tmp[SMP_W-1] : 1'b0;
            if (cap) begin
                s_d.shadow = words_i;
                s_d.take   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pos    <= '1;
            s_q.ws     <= 1'b0;
            s_q.sdata  <= 1'b0;
            s_q.take   <= 1'b0;
            s_q.shadow <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ws_o    = s_q.ws;
    assign sdata_o = s_q.sdata;
    assign take_o  = s_q.take;

    // R2
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.sdata) |-> $fell(bclk_i));

    // R2
    ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.ws) |-> $fell(bclk_i));

    // R12
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.take |=> !s_q.take);

    // R12
    take_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.take |-> $fell(bclk_i));

    // R6
    sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i == FMT_TDM && s_q.ws && step_i) |=> !s_q.ws);

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import txa_pkg::*;
#(
    parameter int          NCH  = 8,
    parameter int          SLOT = 32,
    parameter int          HALF = 2,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           fmt_i,
    input  logic [1:0]           wlen_i,
    input  logic                 pack_i,
    input  logic [NCH*SMP_W-1:0] smp_i,
    output logic                 bclk_o,
    output logic                 ws_o,
    output logic                 sdata_o,
    output logic                 take_o
);
    logic                 step;
    logic                 packed_eff;
    logic [4:0]           bits;
    logic [NCH*SMP_W-1:0] words;

    assign packed_eff = pack_i && (fmt_i != FMT_TDM);
    assign bits       = word_bits(wlen_i, packed_eff);

    txa_clkgen #(.HALF(HALF)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_o (bclk_o),
        .step_o (step)
    );

    txa_dither #(.NCH(NCH), .SEED(SEED)) u_dith (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (smp_i),
        .bits_i (bits),
        .word_o (words)
    );

    txa_framer #(.NCH(NCH), .SLOT(SLOT)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .bclk_i   (bclk_o),
        .fmt_i    (fmt_i),
        .packed_i (packed_eff),
        .bits_i   (bits),
        .words_i  (words),
        .ws_o     (ws_o),
        .sdata_o  (sdata_o),
        .take_o   (take_o)
    );

endmodule

// File: tb/serial_audio_tx_test.sv
module serial_audio_tx_test;
    localparam int NCH  = 8;
    localparam int HALF = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      fmt_i = 2'b00;
    logic [1:0]      wlen_i = 2'b00;
    logic            pack_i = 1'b0;
    logic [NCH*24-1:0] smp_i = '0;
    logic            bclk_o, ws_o, sdata_o, take_o;

    int total = 0;
    int bad = 0;
    int alt_hits = 0;
    int plain_hits = 0;

    always #5 clk = ~clk;

    serial_audio_tx #(.NCH(NCH), .HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .wlen_i(wlen_i), .pack_i(pack_i),
        .smp_i(smp_i), .bclk_o(bclk_o), .ws_o(ws_o), .sdata_o(sdata_o), .take_o(take_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] trunc_w(input logic [23:0] s, input int w);
        logic [23:0] m;
        m = ~((24'd1 << (24 - w)) - 24'd1);
        return s & m;
    endfunction

    function automatic logic [23:0] dith_w(input logic [23:0] s, input int w);
        logic [23:0] sum;
        if (w >= 24) return s;
        sum = s + (24'd1 << (23 - w));
        if (!s[23] && sum[23]) sum = 24'h7FFFFF;
        return trunc_w(sum, w);
    endfunction

    task automatic run_cfg(input int fmt, input int wl, input int pk, input int nfr);
        int pke, nb, slen, flen, dly, nch, pos, q, slot, k, idx, start;
        int cyc, last_rise, done, takes, ntake, ws_bad, zero_bad, per_bad, take_bad, limit;
        bit on, started, prev_b, prev_take, exp_ws;
        string req;
        logic [23:0] cap [8];
        logic [23:0] rx [8];
        logic [23:0] t, a;

        pke  = (pk != 0 && fmt != 2) ? 1 : 0;
        nb   = pke ? 16 : (wl == 0 ? 24 : wl == 1 ? 20 : wl == 2 ? 18 : 16);
        slen = pke ? 16 : 32;
        flen = (fmt == 2) ? 256 : 2 * slen;
        dly  = (fmt == 1) ? 1 : 0;
        nch  = (fmt == 2) ? 8 : 2;
        req  = fmt == 0 ? "R3" : fmt == 1 ? "R4" : fmt == 3 ? "R5" : "R6";
        if (pke) req = "R11";

        fmt_i = 2'(fmt); wlen_i = 2'(wl); pack_i = pk[0];
        for (int c = 0; c < NCH; c++) smp_i[c*24 +: 24] = 24'($urandom);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({bclk_o, ws_o, sdata_o, take_o} == 4'b1000, "R1", "reset outputs",
              {28'd0, bclk_o, ws_o, sdata_o, take_o}, 32'h8);
        rst_n = 1'b1;

        for (int c = 0; c < 8; c++) begin cap[c] = '0; rx[c] = '0; end
        prev_b = 1'b1; prev_take = 1'b0; pos = -1; started = 1'b0;
        cyc = 0; last_rise = -1; done = 0; takes = 0; ntake = 0;
        ws_bad = 0; zero_bad = 0; per_bad = 0; take_bad = 0;
        limit = (nfr + 3) * flen * 2 * HALF + 100;

        while (done < nfr && cyc < limit) begin
            @(negedge clk);
            cyc++;
            if (take_o) begin
                if (prev_take) take_bad++;
                for (int c = 0; c < 8; c++) cap[c] = smp_i[c*24 +: 24];
                takes++; ntake++;
                for (int c = 0; c < NCH; c++) smp_i[c*24 +: 24] = 24'($urandom);
                if (ntake == 2) begin
                    smp_i[23:0]  = 24'h7FFFFF;
                    smp_i[47:24] = 24'h800000;
                end
            end
            prev_take = take_o;
            if (bclk_o && !prev_b) begin
                if (last_rise >= 0 && cyc - last_rise != 2 * HALF) per_bad++;
                last_rise = cyc;
                pos = (pos < 0) ? 0 : (pos + 1) % flen;
                if (fmt == 2) exp_ws = (pos == 0);
                else if (fmt == 1) exp_ws = (pos >= slen);
                else exp_ws = (pos < slen);
                if (ws_o != exp_ws) ws_bad++;
                q    = (pos >= dly) ? pos - dly : flen - 1;
                slot = q / slen;
                k    = q % slen;
                if (fmt == 3) begin
                    start = slen - nb; on = (k >= start); idx = k - start;
                end else begin
                    on = (k < nb); idx = k;
                end
                if (q == 0) begin
                    started = 1'b1;
                    for (int c = 0; c < 8; c++) rx[c] = '0;
                end
                if (on) rx[slot][23 - idx] = sdata_o;
                else if (sdata_o) zero_bad++;
                if (q == flen - 1 && started) begin
                    for (int c = 0; c < nch; c++) begin
                        t = trunc_w(cap[c], nb);
                        a = dith_w(cap[c], nb);
                        if (cap[c] == 24'h7FFFFF)
                            check(rx[c] == t, "R9", "saturated word", {8'd0, rx[c]}, {8'd0, t});
                        else
                            check(rx[c] == t || rx[c] == a, {req, "/R7/R8"}, "channel word",
                                  {8'd0, rx[c]}, {8'd0, t});
                        if (t != a) begin
                            if (rx[c] == a) alt_hits++;
                            else if (rx[c] == t) plain_hits++;
                        end
                    end
                    // R12 one capture per frame
                    check(takes == 1, "R12", "captures per frame", 32'(takes), 32'd1);
                    takes = 0;
                    done++;
                end
            end
            prev_b = bclk_o;
        end
        check(done == nfr, req, "watchdog: frames completed", 32'(done), 32'(nfr));
        check(ws_bad == 0, req, "word select mismatches", 32'(ws_bad), 32'd0);
        check(zero_bad == 0, "R10", "nonzero unused bits", 32'(zero_bad), 32'd0);
        check(per_bad == 0, "R2", "bit clock period errors", 32'(per_bad), 32'd0);
        check(take_bad == 0, "R12", "strobe wider than one cycle", 32'(take_bad), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_cfg(0, 0, 0, 5);   // R3 24 bits
        run_cfg(0, 3, 0, 5);   // R3 R9 16 bits with saturation
        run_cfg(1, 0, 0, 5);   // R4
        run_cfg(1, 1, 0, 5);   // R4 20 bits
        run_cfg(3, 0, 0, 5);   // R5
        run_cfg(3, 2, 0, 5);   // R5 18 bits
        run_cfg(2, 0, 0, 3);   // R6
        run_cfg(2, 3, 0, 3);   // R6 16 bits
        run_cfg(0, 1, 1, 6);   // R11 packed left-justified
        run_cfg(1, 2, 1, 6);   // R11 packed I2S
        run_cfg(3, 0, 1, 6);   // R11 packed right-justified
        run_cfg(2, 1, 1, 3);   // R11 packing ignored in TDM
        for (int i = 0; i < 4; i++) begin
            int f;
            f = int'($urandom_range(3, 0));
            run_cfg(f, int'($urandom_range(3, 0)), int'($urandom_range(1, 0)), f == 2 ? 2 : 5);
        end
        // R8 dither must change some words and leave others
        check(alt_hits > 0 && plain_hits > 0, "R8", "dither outcomes seen",
              32'(alt_hits), 32'(plain_hits));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule